// File: doc/BRIEF.md
# Serial DAC Register Loader and Playback Trigger

This block brings up an external waveform DAC after reset with no processor involved. It walks a fixed list of 33 register settings and sends each one over a 4-wire serial bus as a frame of its own. It then writes the commit register so the DAC moves its shadow settings into use. Once that frame has closed, it pulls the active-low trigger line low for a set number of clocks to start playback.

With the readback pass enabled, the block then reads every listed register back. It compares each value with the one it wrote, skipping the reserved bits. The first register that disagrees is latched for inspection. A start pulse aborts any frame in flight and runs the whole sequence again from the first entry.

Top module: `dac_cfg_seq`

## Requirements
- R1: While reset is held, cs_n and trig_n are 1, and sclk, done and err are 0. When reset releases, the first frame starts without any other input.
- R2: Each frame has CS low for exactly 32 SCLK cycles, and SCLK idles low. Frame bit 31 is the direction flag (1 = read), bits [30:16] are the register address and bits [15:0] are the data. Bits go out MSB first. MOSI changes only on a falling SCLK edge, and MISO is sampled on the rising edge.
- R3: Each SCLK half-period lasts exactly CLK_DIV/2 system clocks.
- R4: CS stays high for at least GAP_SCLK*CLK_DIV system clocks between any two frames.
- R5: The first 33 write frames follow the table order. The first entry is address 0x0000 with data 0x0000. The table also holds 0x0027=0x1232, 0x003E=0x0750, 0x005C=0x0FA0 and 0x005F=0x7FFF.
- R6: The 34th write frame sets address 0x001D to 0x0001, and exactly 34 write frames finish before the trigger falls.
- R7: trig_n falls only after the commit frame's CS has risen. CS stays high while trig_n is low, and trig_n returns high after exactly TRIG_CYC clocks.
- R8: After the trigger, the block sends exactly 33 read frames, one for each table entry. No read frame occurs before the trigger.
- R9: Readback ignores bits [2:0] of registers 0x0001 and 0x0002. Every other bit, including bit 3 of 0x0002, must match.
- R10: The first mismatching register raises err and stores its address in err_addr. Later mismatches leave both unchanged.
- R11: done rises once the readback pass ends, whether or not a mismatch was found. done is low while trig_n is low. Once done is high, no further frames occur until start.
- R12: A start pulse raises CS on the next clock, clears done, err and err_addr, and runs the sequence again from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Restart pulse: aborts and reruns the sequence |
| miso | input | 1 | Serial data from the DAC |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the DAC |
| cs_n | output | 1 | Active-low frame select |
| trig_n | output | 1 | Active-low playback trigger |
| done | output | 1 | Sequence complete |
| err | output | 1 | Readback mismatch seen |
| err_addr | output | 15 | Address of the first mismatching register |

## Verification
Each result has a fixed delay after its cause:
- CS rises and done and err clear one clock after start.
- The first SCLK rise comes CLK_DIV/2 clocks after CS falls.
- The trigger falls GAP_SCLK*CLK_DIV+1 clocks after the commit frame's CS rises, and stays low for TRIG_CYC clocks.

The bench's DAC model and monitor sample every signal on the falling system clock, half a cycle after the registers update. They count the clocks between edges rather than waiting for events. They answer read frames with the reserved bits flipped and with chosen bits corrupted, and the expected error address follows from the table order.

// File: rtl/dac_cfg_pkg.sv
// Shared constants, types and the configuration table for the DAC loader.
// Assumes a 15-bit register address space and 16-bit register data.
package dac_cfg_pkg;

    localparam int unsigned N_CFG = 33;
    localparam int unsigned AW    = 15;
    localparam int unsigned DW    = 16;
    localparam int unsigned IDX_W = $clog2(N_CFG);

    localparam logic [AW-1:0] COMMIT_ADDR = 15'h001D;
    localparam logic [DW-1:0] COMMIT_DATA = 16'h0001;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cfg_pair_t;

    typedef enum logic [2:0] {
        SQ_WRITE,
        SQ_COMMIT,
        SQ_TRIG,
        SQ_VERIFY,
        SQ_DONE
    } seq_state_t;

    // Table entry by index. Sample-memory words keep the 12-bit sample in [15:4].
    function automatic cfg_pair_t cfg_entry(input logic [IDX_W-1:0] idx);
        cfg_pair_t p;
        case (idx)
            6'd0:  p = '{15'h0000, 16'h0000};
            6'd1:  p = '{15'h0001, 16'h0E00};
            6'd2:  p = '{15'h0002, 16'h0400};
            6'd3:  p = '{15'h0003, 16'h0000};
            6'd4:  p = '{15'h0007, 16'h4000};
            6'd5:  p = '{15'h0008, 16'h0000};
            6'd6:  p = '{15'h000C, 16'h1F00};
            6'd7:  p = '{15'h000D, 16'h0010};
            6'd8:  p = '{15'h000E, 16'h0000};
            6'd9:  p = '{15'h001E, 16'h0000};
            6'd10: p = '{15'h001F, 16'h0000};
            6'd11: p = '{15'h0020, 16'h000E};
            6'd12: p = '{15'h0025, 16'h0000};
            6'd13: p = '{15'h0027, 16'h1232};
            6'd14: p = '{15'h0028, 16'h0111};
            6'd15: p = '{15'h0029, 16'h0200};
            6'd16: p = '{15'h002B, 16'h0101};
            6'd17: p = '{15'h002C, 16'h0003};
            6'd18: p = '{15'h002D, 16'h0000};
            6'd19: p = '{15'h0031, 16'h0000};
            6'd20: p = '{15'h0035, 16'h4000};
            6'd21: p = '{15'h0037, 16'h7E00};
            6'd22: p = '{15'h003E, 16'h0750};
            6'd23: p = '{15'h003F, 16'h7500};
            6'd24: p = '{15'h0043, 16'h0000};
            6'd25: p = '{15'h0044, 16'h0002};
            6'd26: p = '{15'h0045, 16'h0000};
            6'd27: p = '{15'h0047, 16'h0000};
            6'd28: p = '{15'h005C, 16'h0FA0};
            6'd29: p = '{15'h005D, 16'h0000};
            6'd30: p = '{15'h005E, 16'h0000};
            6'd31: p = '{15'h005F, 16'h7FFF};
            6'd32: p = '{15'h6000, 16'h7FF0};
            default: p = '{15'h0000, 16'h0000};
        endcase
        return p;
    endfunction

    // Readback compare mask: reserved low bits of two control registers are skipped.
    function automatic logic [DW-1:0] cmp_mask(input logic [AW-1:0] a);
        return ((a == 15'h0001) || (a == 15'h0002)) ? 16'hFFF8 : 16'hFFFF;
    endfunction

endpackage

// File: rtl/cfg_table.sv
// Configuration table lookup: gives the address, data and compare mask of one entry.
// Assumes the index stays below N_CFG; out-of-range entries read as zero.
module cfg_table
    import dac_cfg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output cfg_pair_t        pair,
    output logic [DW-1:0]    mask
);

    // Pure lookup, no state.
    always_comb begin
        pair = cfg_entry(idx);
        mask = cmp_mask(pair.addr);
    end

endmodule

// File: rtl/spi_frame_engine.sv
// One 32-bit serial frame for each go pulse: CS low, 32 SCLK cycles, CS high, then a gap.
// Assumes CLK_DIV is even and at least 2. SCLK idles low. MOSI moves on the falling
// edge and MISO is sampled on the rising edge. abort ends a frame at once and still
// enforces the gap. fin pulses when the gap has elapsed; rx_data holds the last 16 bits read.
module spi_frame_engine #(
    parameter int unsigned CLK_DIV  = 8,
    parameter int unsigned GAP_SCLK = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        abort,
    input  logic [31:0] frame_in,
    input  logic        miso,
    output logic        idle,
    output logic        fin,
    output logic [15:0] rx_data,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n
);

    localparam int unsigned HALF    = CLK_DIV / 2;
    localparam int unsigned HW      = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned GAP_CYC = GAP_SCLK * CLK_DIV;
    localparam int unsigned GW      = $clog2(GAP_CYC + 1);

    typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_state_t;

    eng_state_t      st;
    logic [31:0]     sh;
    logic [15:0]     rx;
    logic [4:0]      bitn;
    logic [HW-1:0]   dcnt;
    logic [GW-1:0]   gcnt;
    logic            sclk_q;
    logic            cs_q;
    logic            fin_q;

    // Frame sequencing: divider, shifting, CS framing and the inter-frame gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= E_IDLE;
            sh     <= '0;
            rx     <= '0;
            bitn   <= '0;
            dcnt   <= '0;
            gcnt   <= '0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (abort) begin
                st     <= E_GAP;
                cs_q   <= 1'b1;
                sclk_q <= 1'b0;
                gcnt   <= '0;
            end else begin
                case (st)
                    E_IDLE: begin
                        if (go) begin
                            st     <= E_SHIFT;
                            sh     <= frame_in;
                            cs_q   <= 1'b0;
                            sclk_q <= 1'b0;
                            dcnt   <= '0;
                            bitn   <= '0;
                        end
                    end
                    E_SHIFT: begin
                        if (dcnt == HW'(HALF - 1)) begin
                            dcnt <= '0;
                            if (!sclk_q) begin
                                sclk_q <= 1'b1;
                                rx     <= {rx[14:0], miso};
                            end else begin
                                sclk_q <= 1'b0;
                                if (bitn == 5'd31) begin
                                    cs_q <= 1'b1;
                                    st   <= E_GAP;
                                    gcnt <= '0;
                                end else begin
                                    sh   <= {sh[30:0], 1'b0};
                                    bitn <= bitn + 5'd1;
                                end
                            end
                        end else begin
                            dcnt <= dcnt + HW'(1);
                        end
                    end
                    E_GAP: begin
                        if (gcnt == GW'(GAP_CYC - 1)) begin
                            st    <= E_IDLE;
                            fin_q <= 1'b1;
                        end else begin
                            gcnt <= gcnt + GW'(1);
                        end
                    end
                    default: st <= E_IDLE;
                endcase
            end
        end
    end

    assign idle    = (st == E_IDLE);
    assign fin     = fin_q;
    assign rx_data = rx;
    assign sclk    = sclk_q;
    assign mosi    = sh[31];
    assign cs_n    = cs_q;

    // Checker counter: clocks with CS high, saturating at the gap length.
    logic [GW-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= GW'(GAP_CYC);
        else if (!cs_q)
            hi_cnt <= '0;
        else if (hi_cnt != GW'(GAP_CYC))
            hi_cnt <= hi_cnt + GW'(1);
    end

    // R4
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= GW'(GAP_CYC)));

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/trig_timer.sv
// Active-low trigger pulse generator: a fire pulse holds the line low for TRIG_CYC clocks.
// Assumes TRIG_CYC >= 1. abort returns the line high at once. fin pulses when the pulse ends.
module trig_timer #(
    parameter int unsigned TRIG_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic abort,
    output logic trig_n,
    output logic fin
);

    localparam int unsigned TW = $clog2(TRIG_CYC + 1);

    logic [TW-1:0] cnt;
    logic          trig_q;
    logic          fin_q;

    // Low-phase timing of the trigger line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b1;
            cnt    <= '0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (abort) begin
                trig_q <= 1'b1;
                cnt    <= '0;
            end else if (fire) begin
                trig_q <= 1'b0;
                cnt    <= '0;
            end else if (!trig_q) begin
                if (cnt == TW'(TRIG_CYC - 1)) begin
                    trig_q <= 1'b1;
                    fin_q  <= 1'b1;
                end else begin
                    cnt <= cnt + TW'(1);
                end
            end
        end
    end

    assign trig_n = trig_q;
    assign fin    = fin_q;

    // R7
    trig_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_n |-> !fire);

endmodule

// File: rtl/dac_cfg_seq.sv
// DAC bring-up sequencer: writes the table, commits, triggers, then optionally reads back.
// Assumes one DAC on the bus. start restarts everything from table entry 0.
// Reset behaves like start, so the sequence runs as soon as reset releases.
module dac_cfg_seq
    import dac_cfg_pkg::*;
#(
    parameter int unsigned CLK_DIV   = 8,
    parameter int unsigned GAP_SCLK  = 4,
    parameter int unsigned TRIG_CYC  = 1000,
    parameter int unsigned VERIFY_EN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          cs_n,
    output logic          trig_n,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] err_addr
);

    seq_state_t        st;
    logic [IDX_W-1:0]  idx;
    logic              wait_f;
    logic              done_q;
    logic              err_q;
    logic [AW-1:0]     err_addr_q;

    cfg_pair_t         pair;
    logic [DW-1:0]     mask;
    logic [31:0]       frame;
    logic              need_frame;
    logic              go;
    logic              eng_idle;
    logic              eng_fin;
    logic [15:0]       rx_data;
    logic              fire;
    logic              trig_fin;
    logic              last_idx;
    logic              mismatch;
    seq_state_t        after_trig;

    cfg_table u_tab (
        .idx  (idx),
        .pair (pair),
        .mask (mask)
    );

    spi_frame_engine #(
        .CLK_DIV  (CLK_DIV),
        .GAP_SCLK (GAP_SCLK)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .abort    (start),
        .frame_in (frame),
        .miso     (miso),
        .idle     (eng_idle),
        .fin      (eng_fin),
        .rx_data  (rx_data),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n)
    );

    trig_timer #(
        .TRIG_CYC (TRIG_CYC)
    ) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .abort  (start),
        .trig_n (trig_n),
        .fin    (trig_fin)
    );

    // Step after the trigger: the readback pass or straight to completion.
    if (VERIFY_EN != 0) begin : g_verify
        assign after_trig = SQ_VERIFY;
    end else begin : g_noverify
        assign after_trig = SQ_DONE;
    end

    // Frame contents for the current step and the handshake with the engine.
    always_comb begin
        case (st)
            SQ_WRITE:  frame = {1'b0, pair.addr, pair.data};
            SQ_COMMIT: frame = {1'b0, COMMIT_ADDR, COMMIT_DATA};
            SQ_VERIFY: frame = {1'b1, pair.addr, 16'h0000};
            default:   frame = '0;
        endcase
        need_frame = (st == SQ_WRITE) || (st == SQ_COMMIT) || (st == SQ_VERIFY);
        go         = need_frame && eng_idle && !wait_f && !start;
        fire       = (st == SQ_COMMIT) && wait_f && eng_fin && !start;
        last_idx   = (idx == IDX_W'(N_CFG - 1));
        mismatch   = ((rx_data ^ pair.data) & mask) != '0;
    end

    // Step sequencing, readback comparison and the result flags.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            st         <= SQ_WRITE;
            idx        <= '0;
            wait_f     <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            err_addr_q <= '0;
        end else begin
            if (go)
                wait_f <= 1'b1;
            case (st)
                SQ_WRITE: begin
                    if (wait_f && eng_fin) begin
                        wait_f <= 1'b0;
                        if (last_idx) st <= SQ_COMMIT;
                        else          idx <= idx + IDX_W'(1);
                    end
                end
                SQ_COMMIT: begin
                    if (wait_f && eng_fin) begin
                        wait_f <= 1'b0;
                        st     <= SQ_TRIG;
                    end
                end
                SQ_TRIG: begin
                    idx <= '0;
                    if (trig_fin) begin
                        st     <= after_trig;
                        done_q <= (after_trig == SQ_DONE);
                    end
                end
                SQ_VERIFY: begin
                    if (wait_f && eng_fin) begin
                        wait_f <= 1'b0;
                        if (mismatch && !err_q) begin
                            err_q      <= 1'b1;
                            err_addr_q <= pair.addr;
                        end
                        if (last_idx) begin
                            st     <= SQ_DONE;
                            done_q <= 1'b1;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                default: st <= SQ_DONE;
            endcase
        end
    end

    assign done     = done_q;
    assign err      = err_q;
    assign err_addr = err_addr_q;

    // R7
    trig_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_n |-> cs_n);

    // R7
    trig_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_n) |-> ($past(st) == SQ_COMMIT));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (trig_n && cs_n));

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> (err && $stable(err_addr)));

    // R12
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cs_n && !done && !err));

endmodule

// File: tb/sim_dac_cfg_seq.sv
// Bench: a behavioural DAC model and a bus monitor, both sampling on the falling clock.
// Runs a clean pass, two corrupted readbacks and a mid-frame restart.
module sim_dac_cfg_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 8;
    localparam int GAP_SCLK   = 4;
    localparam int TRIG_CYC   = 200;
    localparam int HALF       = CLK_DIV / 2;
    localparam int GAP_CYC    = GAP_SCLK * CLK_DIV;
    localparam int WDOG       = 190000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        miso;
    logic        sclk, mosi, cs_n, trig_n, done, err;
    logic [14:0] err_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dac_cfg_seq #(
        .CLK_DIV   (CLK_DIV),
        .GAP_SCLK  (GAP_SCLK),
        .TRIG_CYC  (TRIG_CYC),
        .VERIFY_EN (1)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .trig_n   (trig_n),
        .done     (done),
        .err      (err),
        .err_addr (err_addr)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // DAC model state and fault injection controls
    logic [15:0] mem [logic [14:0]];
    logic [14:0] fault_a, fault_b;
    logic [15:0] fault_m;
    logic        clr_mon;

    function automatic logic [15:0] model_read(input logic [14:0] a);
        logic [15:0] v;
        v = mem.exists(a) ? mem[a] : 16'h0000;
        if (a == 15'h0001 || a == 15'h0002) v[2:0] = ~v[2:0];
        if (a == fault_a || a == fault_b) v = v ^ fault_m;
        return v;
    endfunction

    // Monitor state
    logic        p_cs, p_sclk, p_mosi, p_trig;
    logic [31:0] shreg;
    logic [15:0] rdval;
    logic [14:0] lga [0:63];
    logic [15:0] lgd [0:63];
    int bitcnt, nwr, nrd, gapcnt, halfcnt;
    int half_bad, gap_bad, mosi_bad;
    int trig_falls, wr_at_trig, trig_len, trig_len_last, trig_cs_bad, trig_done_bad;
    int rd_before_trig;

    // DAC model plus bus monitor, evaluated half a cycle after each register update.
    always @(negedge clk) begin
        if (!rst_n || clr_mon) begin
            p_cs = cs_n; p_sclk = sclk; p_mosi = mosi; p_trig = trig_n;
            bitcnt = 0; nwr = 0; nrd = 0; gapcnt = 100000; halfcnt = 0;
            half_bad = 0; gap_bad = 0; mosi_bad = 0;
            trig_falls = 0; wr_at_trig = -1; trig_len = 0; trig_len_last = -1;
            trig_cs_bad = 0; trig_done_bad = 0; rd_before_trig = 0;
            miso = 1'b0;
        end else begin
            if (p_cs && !cs_n) begin
                if (gapcnt + 1 < GAP_CYC) gap_bad++;
                bitcnt = 0;
                halfcnt = 0;
            end else if (!cs_n) begin
                halfcnt++;
                if (sclk != p_sclk) begin
                    if (halfcnt != HALF) half_bad++;
                    halfcnt = 0;
                end
            end
            if (!cs_n && !p_sclk && sclk) begin
                shreg = {shreg[30:0], mosi};
                bitcnt++;
            end
            if (!cs_n && !p_cs && (mosi != p_mosi) && !(p_sclk && !sclk)) mosi_bad++;
            if (!cs_n && p_sclk && !sclk) begin
                if (bitcnt == 16) begin
                    rdval = model_read(shreg[14:0]);
                    miso = rdval[15];
                end else if (bitcnt > 16 && bitcnt < 32) begin
                    miso = rdval[31 - bitcnt];
                end
            end
            if (!p_cs && cs_n) begin
                if (bitcnt == 32) begin
                    if (shreg[31]) begin
                        nrd++;
                        if (trig_falls == 0) rd_before_trig++;
                    end else begin
                        mem[shreg[30:16]] = shreg[15:0];
                        if (nwr < 64) begin
                            lga[nwr] = shreg[30:16];
                            lgd[nwr] = shreg[15:0];
                        end
                        nwr++;
                    end
                end
                gapcnt = 0;
            end else if (cs_n) begin
                gapcnt++;
            end
            if (p_trig && !trig_n) begin
                trig_falls++;
                wr_at_trig = nwr;
                trig_len = 0;
            end
            if (!trig_n) begin
                trig_len++;
                if (!cs_n) trig_cs_bad++;
                if (done) trig_done_bad++;
            end
            if (!p_trig && trig_n) trig_len_last = trig_len;
            p_cs = cs_n; p_sclk = sclk; p_mosi = mosi; p_trig = trig_n;
        end
    end

    function automatic int has_pair(input logic [14:0] a, input logic [15:0] d);
        for (int i = 0; i < 33; i++)
            if (lga[i] == a && lgd[i] == d) return 1;
        return 0;
    endfunction

    task automatic pulse_start();
        @(negedge clk); #1;
        start = 1'b1; clr_mon = 1'b1;
        @(negedge clk); #1;
        start = 1'b0; clr_mon = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 60000) begin
            @(negedge clk);
            t++;
        end
        chk(req, int'(done), 1);
    endtask

    // Checks common to every completed run
    task automatic check_run();
        chk("R5 first entry address", int'(lga[0]), 0);
        chk("R5 first entry data", int'(lgd[0]), 0);
        chk("R5 entry 0x0027", has_pair(15'h0027, 16'h1232), 1);
        chk("R5 entry 0x003E", has_pair(15'h003E, 16'h0750), 1);
        chk("R5 entry 0x005C", has_pair(15'h005C, 16'h0FA0), 1);
        chk("R5 entry 0x005F", has_pair(15'h005F, 16'h7FFF), 1);
        chk("R6 writes before trigger", wr_at_trig, 34);
        chk("R6 commit address", int'(lga[33]), 'h1D);
        chk("R6 commit data", int'(lgd[33]), 1);
        chk("R7 trigger falls once", trig_falls, 1);
        chk("R7 trigger low length", trig_len_last, TRIG_CYC);
        chk("R7 CS high during trigger", trig_cs_bad, 0);
        chk("R11 done low during trigger", trig_done_bad, 0);
        chk("R8 read frames", nrd, 33);
        chk("R8 reads before trigger", rd_before_trig, 0);
        chk("R2 MOSI moves only on falling SCLK", mosi_bad, 0);
        chk("R3 SCLK half-period", half_bad, 0);
        chk("R4 CS gap", gap_bad, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports the summary.
    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R11 watchdog: actual %0d expected %0d", WDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int nwr0;
        rst_n = 1'b0; start = 1'b0; clr_mon = 1'b0;
        fault_a = 15'h7FFF; fault_b = 15'h7FFF; fault_m = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", int'(cs_n), 1);
        chk("R1 trig_n in reset", int'(trig_n), 1);
        chk("R1 sclk in reset", int'(sclk), 0);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 err in reset", int'(err), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 first frame starts after reset", int'(cs_n), 0);

        // Clean run: reserved bits of 0x0001/0x0002 read back flipped
        wait_done("R11 done after clean run");
        check_run();
        chk("R9 reserved bits ignored", int'(err), 0);
        nwr0 = nwr;
        repeat (2000) @(negedge clk);
        chk("R11 no frames after done", nwr + nrd, nwr0 + 33);
        chk("R11 done holds", int'(done), 1);

        // Two corrupted registers: the earlier one in table order is reported
        fault_a = 15'h003E; fault_b = 15'h0027; fault_m = 16'h0010;
        pulse_start();
        chk("R12 done cleared by start", int'(done), 0);
        wait_done("R11 done despite mismatch");
        check_run();
        chk("R10 err raised", int'(err), 1);
        chk("R10 first mismatch address", int'(err_addr), 'h27);

        // Lowest compared bit of 0x0002 corrupted
        fault_a = 15'h0002; fault_b = 15'h7FFF; fault_m = 16'h0008;
        pulse_start();
        chk("R12 err cleared by start", int'(err), 0);
        chk("R12 err_addr cleared by start", int'(err_addr), 0);
        wait_done("R11 done with bit-3 fault");
        chk("R9 bit 3 of 0x0002 compared", int'(err), 1);
        chk("R9 mismatch address 0x0002", int'(err_addr), 2);

        // Reserved bit 2 of 0x0001 corrupted, restart in the middle of a frame
        fault_a = 15'h0001; fault_m = 16'h0004;
        pulse_start();
        while (cs_n) @(negedge clk);
        repeat (5) @(negedge clk);
        #1 start = 1'b1; clr_mon = 1'b1;
        @(negedge clk);
        chk("R12 CS high one clock after start", int'(cs_n), 1);
        chk("R12 done low after start", int'(done), 0);
        #1 start = 1'b0; clr_mon = 1'b0;
        wait_done("R12 rerun completes");
        check_run();
        chk("R9 reserved bit 2 of 0x0001 ignored", int'(err), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule